// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This block decides the control-flow outcome of one instruction word. It checks whether the word uses the jump format. If it does, it tests the selected condition against the negative, zero, carry and overflow flags. It then produces the program counter that execution continues from.

The caller supplies a program counter that already points past the jump word. A taken branch adds twice the sign-extended 10-bit word offset to that value. A branch that is not taken, and any word that is not a jump, leaves the value unchanged.

The flags are passed through untouched, because a jump never alters them. All results are registered and appear one clock after a single-cycle request strobe.

Top module: `branch_step_unit`

## Requirements
- R1: A word is a jump only when bits 15:13 equal binary 001. `is_jump_o` shows this. A word with any other value there gives `is_jump_o`=0 and `taken_o`=0.
- R2: Condition field bits 12:10 = 000 is taken when Z=0. Code 001 is taken when Z=1.
- R3: Condition code 010 is taken when C=0. Code 011 is taken when C=1.
- R4: Condition code 100 is taken when N=1. Code 101 is taken when N equals V. Code 110 is taken when N differs from V.
- R5: Condition code 111 is taken whatever the flags are.
- R6: When taken, `next_pc_o` equals `pc_i` plus two times bits 9:0 read as a signed two's-complement word offset, modulo 2^16. The offset reaches from -512 to +511 words.
- R7: When not taken, including a non-jump word, `next_pc_o` equals `pc_i`.
- R8: Bit 0 of `next_pc_o` is always 0, even when `pc_i` is odd.
- R9: `flags_o` equals the flags presented with the strobe, so a jump never changes them. The order is {N,Z,C,V} from bit 3 down to bit 0.
- R10: Results appear on the clock edge after the strobe, and `valid_o` is high for that one cycle only. With no strobe, `is_jump_o`, `taken_o`, `next_pc_o` and `flags_o` hold their previous values.
- R11: While `rst_n` is low at a clock edge, every output is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strobe_i | input | 1 | Request: evaluate the inputs this cycle |
| insn_i | input | 16 | Instruction word |
| pc_i | input | 16 | Program counter, already advanced past the word |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| flag_v_i | input | 1 | Overflow flag |
| valid_o | output | 1 | Result valid pulse |
| is_jump_o | output | 1 | Word is in jump format |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | 16 | Program counter to continue from |
| flags_o | output | 4 | Flags passed through {N,Z,C,V} |

## Verification
Two functions can meet in one cycle: the offset addition and the clearing of bit 0. The 16-bit wrap of the address sum can also land in that same result. The bench provokes this with a taken jump from an odd or near-top program counter. It judges the result against a hand-computed target that must be even and wrapped.

A second overlap happens when strobes come back to back. One result is then on the outputs while the next is being latched. The bench checks that each result appears exactly one cycle after its own strobe and is never mixed with its neighbour.

// File: rtl/brs_pkg.sv
// Package: shared types and constants for the branch resolution unit.
// Assumes the jump format tag sits in the top three bits of the word.
package brs_pkg;

    localparam logic [2:0] JUMP_TAG = 3'b001;

    typedef enum logic [2:0] {
        CC_ZERO_CLR = 3'b000,
        CC_ZERO_SET = 3'b001,
        CC_CARRY_CLR = 3'b010,
        CC_CARRY_SET = 3'b011,
        CC_NEG_SET  = 3'b100,
        CC_SGN_GE   = 3'b101,
        CC_SGN_LT   = 3'b110,
        CC_ALWAYS   = 3'b111
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/brs_field_split.sv
// Module: splits an instruction word into jump tag test, condition and offset.
// Assumes tag in the top 3 bits, condition in the next 3, offset in the low OFF_W bits.
module brs_field_split
    import brs_pkg::*;
#(
    parameter int INSN_W = 16,
    parameter int OFF_W  = 10
) (
    input  logic [INSN_W-1:0] word_i,
    output logic              is_jump_o,
    output cond_e             cond_o,
    output logic [OFF_W-1:0]  offset_o
);
    localparam int TAG_LSB  = INSN_W - 3;
    localparam int COND_LSB = TAG_LSB - 3;

    // Field extraction from fixed positions.
    always_comb begin
        is_jump_o = (word_i[INSN_W-1:TAG_LSB] == JUMP_TAG);
        cond_o    = cond_e'(word_i[COND_LSB+2:COND_LSB]);
        offset_o  = word_i[OFF_W-1:0];
    end
endmodule

// File: rtl/brs_cond_eval.sv
// Module: evaluates the 3-bit branch condition against the status flags.
// Assumes flags are sampled in the same cycle as the condition; purely combinational.
module brs_cond_eval
    import brs_pkg::*;
(
    input  cond_e  cond_i,
    input  flags_t flags_i,
    output logic   hit_o
);
    logic sgn_lt;

    // Signed less-than is N differing from V.
    always_comb sgn_lt = flags_i.n ^ flags_i.v;

    // Condition selection.
    always_comb begin
        unique case (cond_i)
            CC_ZERO_CLR:  hit_o = ~flags_i.z;
            CC_ZERO_SET:  hit_o = flags_i.z;
            CC_CARRY_CLR: hit_o = ~flags_i.c;
            CC_CARRY_SET: hit_o = flags_i.c;
            CC_NEG_SET:   hit_o = flags_i.n;
            CC_SGN_GE:    hit_o = ~sgn_lt;
            CC_SGN_LT:    hit_o = sgn_lt;
            CC_ALWAYS:    hit_o = 1'b1;
            default:      hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/brs_target_calc.sv
// Module: forms the continuation address from the advanced PC and a word offset.
// Assumes OFF_W+1 <= ADDR_W; the sum wraps modulo 2^ADDR_W and bit 0 is cleared.
module brs_target_calc #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 10
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [OFF_W-1:0]  offset_i,
    input  logic              take_i,
    output logic [ADDR_W-1:0] next_pc_o
);
    localparam int EXT_W = ADDR_W - OFF_W - 1;

    logic [ADDR_W-1:0] byte_disp;
    logic [ADDR_W-1:0] sum;

    // Sign-extend the word offset and scale it to bytes.
    generate
        if (EXT_W > 0) begin : g_ext
            always_comb byte_disp = {{EXT_W{offset_i[OFF_W-1]}}, offset_i, 1'b0};
        end else begin : g_noext
            always_comb byte_disp = {offset_i, 1'b0};
        end
    endgenerate

    // Pick the target or the fall-through address, then force even alignment.
    always_comb begin
        sum       = take_i ? (pc_i + byte_disp) : pc_i;
        next_pc_o = {sum[ADDR_W-1:1], 1'b0};
    end
endmodule

// File: rtl/branch_step_unit.sv
// Module: top of the branch resolution unit; registers decode, condition and target.
// Assumes strobe_i is a one-cycle request and pc_i already points past the jump word.
module branch_step_unit
    import brs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int INSN_W = 16,
    parameter int OFF_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic [INSN_W-1:0] insn_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              flag_n_i,
    input  logic              flag_z_i,
    input  logic              flag_c_i,
    input  logic              flag_v_i,
    output logic              valid_o,
    output logic              is_jump_o,
    output logic              taken_o,
    output logic [ADDR_W-1:0] next_pc_o,
    output logic [3:0]        flags_o
);
    logic              dec_jump;
    cond_e             dec_cond;
    logic [OFF_W-1:0]  dec_off;
    flags_t            cur_flags;
    logic              cond_hit;
    logic              take;
    logic [ADDR_W-1:0] tgt_pc;

    // Gather the loose flag pins into one record.
    always_comb cur_flags = '{n: flag_n_i, z: flag_z_i, c: flag_c_i, v: flag_v_i};

    brs_field_split #(.INSN_W(INSN_W), .OFF_W(OFF_W)) u_split (
        .word_i    (insn_i),
        .is_jump_o (dec_jump),
        .cond_o    (dec_cond),
        .offset_o  (dec_off)
    );

    brs_cond_eval u_cond (
        .cond_i  (dec_cond),
        .flags_i (cur_flags),
        .hit_o   (cond_hit)
    );

    // A branch is taken only for a jump word whose condition holds.
    always_comb take = dec_jump & cond_hit;

    brs_target_calc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_tgt (
        .pc_i      (pc_i),
        .offset_i  (dec_off),
        .take_i    (take),
        .next_pc_o (tgt_pc)
    );

    // Result registers: clear on reset, load on strobe, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o   <= 1'b0;
            is_jump_o <= 1'b0;
            taken_o   <= 1'b0;
            next_pc_o <= '0;
            flags_o   <= '0;
        end else begin
            valid_o <= strobe_i;
            if (strobe_i) begin
                is_jump_o <= dec_jump;
                taken_o   <= take;
                next_pc_o <= tgt_pc;
                flags_o   <= cur_flags;
            end
        end
    end
endmodule

// File: rtl/brs_checker.sv
// Checker: temporal properties of branch_step_unit, attached by bind.
// Assumes the default 16-bit word and 10-bit offset layout for the condition probes.
module brs_checker #(
    parameter int ADDR_W = 16,
    parameter int INSN_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strobe_i,
    input logic [INSN_W-1:0] insn_i,
    input logic [ADDR_W-1:0] pc_i,
    input logic              flag_n_i,
    input logic              flag_z_i,
    input logic              flag_c_i,
    input logic              flag_v_i,
    input logic              valid_o,
    input logic              is_jump_o,
    input logic              taken_o,
    input logic [ADDR_W-1:0] next_pc_o,
    input logic [3:0]        flags_o
);
    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> valid_o); // R10
    AST_VALID_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> !valid_o); // R10
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> ($stable(next_pc_o) && $stable(taken_o) && $stable(flags_o))); // R10
    AST_NONJUMP_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && insn_i[INSN_W-1:INSN_W-3] != 3'b001) |=> (!is_jump_o && !taken_o)); // R1
    AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && insn_i[INSN_W-1:INSN_W-6] == 6'b001111) |=> taken_o); // R5
    AST_FALLTHROUGH_PC: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> (taken_o || next_pc_o == {$past(pc_i[ADDR_W-1:1]), 1'b0})); // R7
    AST_PC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !next_pc_o[0]); // R8
    AST_FLAGS_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> flags_o == $past({flag_n_i, flag_z_i, flag_c_i, flag_v_i})); // R9
endmodule

bind branch_step_unit brs_checker #(.ADDR_W(ADDR_W), .INSN_W(INSN_W)) u_brs_chk (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .insn_i(insn_i), .pc_i(pc_i),
    .flag_n_i(flag_n_i), .flag_z_i(flag_z_i), .flag_c_i(flag_c_i), .flag_v_i(flag_v_i),
    .valid_o(valid_o), .is_jump_o(is_jump_o), .taken_o(taken_o),
    .next_pc_o(next_pc_o), .flags_o(flags_o)
);

// File: tb/sim_branch_step_unit.sv
`timescale 1ns/1ps
module sim_branch_step_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe_i = 1'b0;
    logic [15:0] insn_i = '0;
    logic [15:0] pc_i = '0;
    logic        flag_n_i = 1'b0, flag_z_i = 1'b0, flag_c_i = 1'b0, flag_v_i = 1'b0;
    logic        valid_o, is_jump_o, taken_o;
    logic [15:0] next_pc_o;
    logic [3:0]  flags_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    branch_step_unit u0 (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .insn_i(insn_i), .pc_i(pc_i),
        .flag_n_i(flag_n_i), .flag_z_i(flag_z_i), .flag_c_i(flag_c_i), .flag_v_i(flag_v_i),
        .valid_o(valid_o), .is_jump_o(is_jump_o), .taken_o(taken_o),
        .next_pc_o(next_pc_o), .flags_o(flags_o)
    );

    // Vector: {insn, pc, flags NZCV, exp_jump, exp_taken, exp_next_pc}
    localparam int NV = 21;
    localparam logic [53:0] VEC [NV] = '{
        {16'h2FE4, 16'h0200, 4'b0010, 1'b1, 1'b1, 16'h01C8}, // R3 carry set, -0x1C
        {16'h2FE4, 16'h0200, 4'b0000, 1'b1, 1'b0, 16'h0200}, // R3
        {16'h3FE3, 16'h0300, 4'b0000, 1'b1, 1'b1, 16'h02C6}, // R5 -0x1D
        {16'h2005, 16'h1000, 4'b0000, 1'b1, 1'b1, 16'h100A}, // R2 Z clear
        {16'h2005, 16'h1000, 4'b0100, 1'b1, 1'b0, 16'h1000}, // R2
        {16'h2410, 16'h0400, 4'b0100, 1'b1, 1'b1, 16'h0420}, // R2 Z set
        {16'h2410, 16'h0400, 4'b0000, 1'b1, 1'b0, 16'h0400}, // R2
        {16'h2801, 16'h0010, 4'b0000, 1'b1, 1'b1, 16'h0012}, // R3 C clear
        {16'h2801, 16'h0010, 4'b0010, 1'b1, 1'b0, 16'h0010}, // R3
        {16'h31FF, 16'h0100, 4'b1000, 1'b1, 1'b1, 16'h04FE}, // R4 N, +511 words
        {16'h31FF, 16'h0100, 4'b0000, 1'b1, 1'b0, 16'h0100}, // R4
        {16'h3600, 16'h1000, 4'b1001, 1'b1, 1'b1, 16'h0C00}, // R4 N==V, -512 words
        {16'h3600, 16'h1000, 4'b1000, 1'b1, 1'b0, 16'h1000}, // R4
        {16'h3802, 16'h2000, 4'b0001, 1'b1, 1'b1, 16'h2004}, // R4 N!=V
        {16'h3802, 16'h2000, 4'b1001, 1'b1, 1'b0, 16'h2000}, // R4
        {16'h4504, 16'h0050, 4'b1111, 1'b0, 1'b0, 16'h0050}, // R1 non-jump
        {16'h1005, 16'h0060, 4'b0000, 1'b0, 1'b0, 16'h0060}, // R1
        {16'hDFFF, 16'h0008, 4'b1111, 1'b0, 1'b0, 16'h0008}, // R1
        {16'h3C10, 16'hFFF0, 4'b0000, 1'b1, 1'b1, 16'h0010}, // R6 wrap
        {16'h3C00, 16'h1235, 4'b0110, 1'b1, 1'b1, 16'h1234}, // R8 odd pc, taken
        {16'h5315, 16'h0777, 4'b0000, 1'b0, 1'b0, 16'h0776}  // R8 odd pc, non-jump
    };

    function automatic string tag_of(input logic [15:0] w);
        if (w[15:13] != 3'b001) return "R1";
        case (w[12:10])
            3'b000, 3'b001: return "R2";
            3'b010, 3'b011: return "R3";
            3'b111:         return "R5";
            default:        return "R4";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] w, input logic [15:0] pc, input logic [3:0] f);
        insn_i = w;
        pc_i = pc;
        {flag_n_i, flag_z_i, flag_c_i, flag_v_i} = f;
        strobe_i = 1'b1;
    endtask

    task automatic run_vec(input int k);
        logic [53:0] v = VEC[k];
        @(negedge clk);
        drive(v[53:38], v[37:22], v[21:18]);
        @(negedge clk);
        strobe_i = 1'b0;
        check("R10 valid", 32'(valid_o), 32'd1);
        check({tag_of(v[53:38]), " jump"}, 32'(is_jump_o), 32'(v[17]));
        check({tag_of(v[53:38]), " taken"}, 32'(taken_o), 32'(v[16]));
        check(v[16] ? "R6 next_pc" : "R7 next_pc", 32'(next_pc_o), 32'(v[15:0]));
        check("R9 flags", 32'(flags_o), 32'(v[21:18]));
    endtask

    initial begin
        // R11: reset with a live strobe and a taken jump on the inputs
        drive(16'h3C05, 16'h1111, 4'b1111);
        repeat (3) @(negedge clk);
        check("R11 valid", 32'(valid_o), 32'd0);
        check("R11 is_jump", 32'(is_jump_o), 32'd0);
        check("R11 taken", 32'(taken_o), 32'd0);
        check("R11 next_pc", 32'(next_pc_o), 32'd0);
        check("R11 flags", 32'(flags_o), 32'd0);
        strobe_i = 1'b0;
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) run_vec(k);

        // R10: idle cycles hold the last result and drop valid
        drive(16'h2410, 16'h0400, 4'b0100);
        @(negedge clk);
        strobe_i = 1'b0;
        drive(16'h3C40, 16'h5000, 4'b1010);
        strobe_i = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 idle valid", 32'(valid_o), 32'd0);
        check("R10 idle hold pc", 32'(next_pc_o), 32'h0420);
        check("R10 idle hold taken", 32'(taken_o), 32'd1);
        check("R10 idle hold flags", 32'(flags_o), 32'b0100);

        // R10: back-to-back strobes, each result one cycle after its own strobe
        @(negedge clk);
        drive(16'h3C01, 16'h0100, 4'b0000);
        @(negedge clk);
        check("R10 b2b first pc", 32'(next_pc_o), 32'h0102);
        drive(16'h2001, 16'h0200, 4'b0100);
        @(negedge clk);
        strobe_i = 1'b0;
        check("R10 b2b second valid", 32'(valid_o), 32'd1);
        check("R10 b2b second taken", 32'(taken_o), 32'd0);
        check("R7 b2b second pc", 32'(next_pc_o), 32'h0200);

        // R8 + R6: taken jump from odd pc that also wraps past the top
        @(negedge clk);
        drive(16'h3C08, 16'hFFF7, 4'b0000);
        @(negedge clk);
        strobe_i = 1'b0;
        check("R8 odd wrap pc", 32'(next_pc_o), 32'h0006);

        // R11: synchronous reset clears a held result
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 re-reset pc", 32'(next_pc_o), 32'd0);
        check("R11 re-reset jump", 32'(is_jump_o), 32'd0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R10 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule